// File: doc/BRIEF.md
# Bit-Test and Logic Execution Unit

This unit is one execution slice of a 32-bit data path. Each accepted operation takes a destination operand and applies one of eight operations to it. Three are single-bit test-and-modify operations: change, clear or set one bit. The other five are clear, bitwise invert, exclusive OR with a source register, half-word swap and operand test. The unit also keeps the negative (N) and zero (Z) flags.

Operations run at byte, word or long size. Bits above the selected size pass through unchanged. A bit operation first copies the old state of its target bit into Z and only then modifies that bit. When the destination lies in memory, the unit flags a word or long access to an odd address as a fault. It also flags an illegal size code. In both cases the operand comes back unchanged and the flags keep their values.

Results are registered and appear one clock cycle after the operation is presented with `in_valid`. Instruction decode, address calculation and carry/overflow arithmetic are handled elsewhere.

Top module: `bitlogic_unit`

## Requirements
- R1: While `rst` is high, and after its release until the first accepted operation, `out_valid`, `result`, `flag_n`, `flag_z`, `align_fault` and `size_fault` are all 0.
- R2: An operation sampled with `in_valid` high at a rising edge is reflected on the outputs right after that edge, with `out_valid` high. With `in_valid` low, `out_valid` and both fault outputs go to 0, and `result` and the flags hold their values.
- R3: Bit change (`op`=0) sets Z to 1 if the selected bit was 0 and to 0 if it was 1. It then inverts that bit. N is unchanged.
- R4: Bit clear (`op`=1) and bit set (`op`=2) update Z from the old bit as in R3. They then force the bit to 0 or to 1; N is unchanged.
- R5: For bit operations the bit number is taken modulo 8 at byte size (`size`=0) and modulo 32 at long size (`size`=2). For every byte-size operation, `result` bits 31..8 equal the destination bits 31..8.
- R6: The unit raises `size_fault` in two cases: a bit operation at word size (`size`=1), or size code 3 with any operation except swap. On a size fault, `result` equals the destination and N and Z keep their values.
- R7: Clear (`op`=3) zeroes the destination at the selected size (8, 16 or 32 low bits) and keeps the bits above. It sets N to 0 and Z to 1.
- R8: NOT (`op`=4) inverts, and XOR (`op`=5) combines with `src`, the low bits at the selected size. The bits above are preserved. N is the top bit of the sized result, and Z is 1 when the sized result is zero.
- R9: Test (`op`=7) returns the destination unchanged. It sets N from the top bit of the sized operand, and sets Z to 1 when the sized operand is zero.
- R10: Swap (`op`=6) exchanges bits 31..16 with bits 15..0 and sets N and Z from the 32-bit result. It ignores `size`, `mem_dst` and `addr`.
- R11: With `mem_dst` high, a word or long operation with `addr` bit 0 set raises `align_fault`. It returns the destination unchanged and keeps N and Z. A byte operation is accepted at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (see requirements) |
| size | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| bitnum | input | 8 | Bit number for bit operations |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source register for XOR |
| mem_dst | input | 1 | Destination lies in memory |
| addr | input | 24 | Destination address when in memory |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| align_fault | output | 1 | Odd word/long memory access |
| size_fault | output | 1 | Illegal size for the operation |

## Verification
The bench builds the unit with its default widths: a 32-bit operand, an 8-bit byte lane, an 8-bit bit-number field and a 24-bit address. With an 8-bit bit number, values of 32 and above can be applied, so the modulo-32 wrap at long size and the modulo-8 wrap at byte size can both be reached. Sequences are ordered so that fault cases land on known flag values, which shows that flags hold. Swap is applied with an illegal size and an odd memory address to show that it ignores both.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

  typedef enum logic [2:0] {
    OP_BCHG = 3'd0,
    OP_BCLR = 3'd1,
    OP_BSET = 3'd2,
    OP_CLR  = 3'd3,
    OP_NOT  = 3'd4,
    OP_XOR  = 3'd5,
    OP_SWAP = 3'd6,
    OP_TEST = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  function automatic logic is_bit_op(input op_e o);
    return (o == OP_BCHG) || (o == OP_BCLR) || (o == OP_BSET);
  endfunction

endpackage

// File: rtl/bitlogic_bitop.sv
module bitlogic_bitop
  import bitlogic_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 8
) (
  input  op_e                 op,
  input  logic                is_long,
  input  logic [BITNUM_W-1:0] bitnum,
  input  logic [DATA_W-1:0]   dst,
  output logic [DATA_W-1:0]   res,
  output logic                old_bit
);
  localparam int LIDX_W = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [LIDX_W-1:0] idx;
  logic [DATA_W-1:0] sel;
  logic              new_bit;
  logic              unused_bitnum_hi;

  assign unused_bitnum_hi = ^bitnum[BITNUM_W-1:LIDX_W];

  always_comb begin
    idx = '0;
    if (is_long) idx = bitnum[LIDX_W-1:0];
    else         idx[BIDX_W-1:0] = bitnum[BIDX_W-1:0];
  end

  assign sel     = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  assign old_bit = |(dst & sel);

  always_comb begin
    case (op)
      OP_BCLR: new_bit = 1'b0;
      OP_BSET: new_bit = 1'b1;
      default: new_bit = ~old_bit;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res[i] = sel[i] ? new_bit : dst[i];
  end

endmodule

// File: rtl/bitlogic_logic.sv
module bitlogic_logic
  import bitlogic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  op_e               op,
  input  size_e             size,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              zero
);
  localparam int WORD_W = DATA_W / 2;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] raw;
  logic              is_swap;

  assign is_swap = (op == OP_SWAP);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = is_swap || (i < BYTE_W) || (size == SZ_LONG) ||
                     ((size == SZ_WORD) && (i < WORD_W));
  end

  always_comb begin
    case (op)
      OP_CLR:  raw = '0;
      OP_NOT:  raw = ~dst;
      OP_XOR:  raw = dst ^ src;
      OP_SWAP: raw = {dst[WORD_W-1:0], dst[DATA_W-1:WORD_W]};
      default: raw = dst;
    endcase
  end

  assign res  = (raw & mask) | (dst & ~mask);
  assign zero = ((res & mask) == '0);

  always_comb begin
    if (is_swap || size == SZ_LONG) neg = res[DATA_W-1];
    else if (size == SZ_WORD)       neg = res[WORD_W-1];
    else                            neg = res[BYTE_W-1];
  end

endmodule

// File: rtl/bitlogic_check.sv
module bitlogic_check
  import bitlogic_pkg::*;
(
  input  op_e   op,
  input  size_e size,
  input  logic  mem_dst,
  input  logic  addr_lsb,
  output logic  align_fault,
  output logic  size_fault
);
  logic reg_only;
  logic multi_byte;

  assign reg_only   = (op == OP_SWAP);
  assign multi_byte = (size == SZ_WORD) || (size == SZ_LONG);

  assign size_fault  = !reg_only &&
                       ((size == SZ_RSVD) || (is_bit_op(op) && size == SZ_WORD));
  assign align_fault = !reg_only && mem_dst && addr_lsb && multi_byte;

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 8,
  parameter int ADDR_W   = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [1:0]          size,
  input  logic [BITNUM_W-1:0] bitnum,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  input  logic                mem_dst,
  input  logic [ADDR_W-1:0]   addr,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                flag_n,
  output logic                flag_z,
  output logic                align_fault,
  output logic                size_fault
);
  op_e               op_c;
  size_e             size_c;
  logic [DATA_W-1:0] bit_res;
  logic [DATA_W-1:0] log_res;
  logic              bit_old;
  logic              log_n;
  logic              log_z;
  logic              af_c;
  logic              sf_c;
  logic              any_fault;
  logic              bit_path;
  logic              unused_addr_hi;

  assign op_c           = op_e'(op);
  assign size_c         = size_e'(size);
  assign unused_addr_hi = ^addr[ADDR_W-1:1];
  assign any_fault      = af_c || sf_c;
  assign bit_path       = is_bit_op(op_c);

  bitlogic_bitop #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .BITNUM_W(BITNUM_W)
  ) u_bitop (
    .op(op_c), .is_long(size_c == SZ_LONG), .bitnum(bitnum),
    .dst(dst), .res(bit_res), .old_bit(bit_old)
  );

  bitlogic_logic #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_logic (
    .op(op_c), .size(size_c), .dst(dst), .src(src),
    .res(log_res), .neg(log_n), .zero(log_z)
  );

  bitlogic_check u_check (
    .op(op_c), .size(size_c), .mem_dst(mem_dst), .addr_lsb(addr[0]),
    .align_fault(af_c), .size_fault(sf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
      align_fault <= 1'b0;
      size_fault  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      align_fault <= in_valid && af_c;
      size_fault  <= in_valid && sf_c;
      if (in_valid) begin
        if (any_fault) begin
          result <= dst;
        end else if (bit_path) begin
          result <= bit_res;
          flag_z <= !bit_old;
        end else begin
          result <= log_res;
          flag_n <= log_n;
          flag_z <= log_z;
        end
      end
    end
  end

endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] dst,
  input logic              mem_dst,
  input logic              addr_lsb,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              align_fault,
  input logic              size_fault
);
  localparam int WORD_W = DATA_W / 2;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  // R6 and R11: any fault keeps both flags
  p_fault_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && (align_fault || size_fault) |-> $stable(flag_n) && $stable(flag_z));

  p_bitop_word_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && op <= 3'd2 && size == 2'd1)
      |-> size_fault && result == $past(dst));

  p_bitop_keeps_n_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && op <= 3'd2) |-> $stable(flag_n));

  p_swap_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && op == 3'd6)
      |-> result == {$past(dst[WORD_W-1:0]), $past(dst[DATA_W-1:WORD_W])} &&
          !align_fault && !size_fault);

  p_clear_long_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && op == 3'd3 && size == 2'd2 && !mem_dst)
      |-> result == '0 && flag_z && !flag_n);

  p_byte_upper_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && size == 2'd0 && op != 3'd6)
      |-> result[DATA_W-1:BYTE_W] == $past(dst[DATA_W-1:BYTE_W]));

  p_odd_word_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid && mem_dst && addr_lsb && size == 2'd1 && op != 3'd6)
      |-> align_fault);

endmodule

bind bitlogic_unit bitlogic_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size), .dst(dst),
  .mem_dst(mem_dst), .addr_lsb(addr[0]), .out_valid(out_valid), .result(result),
  .flag_n(flag_n), .flag_z(flag_z), .align_fault(align_fault), .size_fault(size_fault)
);

// File: tb/bitlogic_unit_test.sv
`timescale 1ns/1ps
module bitlogic_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [7:0]  bitnum;
  logic [31:0] dst;
  logic [31:0] src;
  logic        mem_dst;
  logic [23:0] addr;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_n;
  logic        flag_z;
  logic        align_fault;
  logic        size_fault;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bitlogic_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .bitnum(bitnum), .dst(dst), .src(src), .mem_dst(mem_dst), .addr(addr),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .align_fault(align_fault), .size_fault(size_fault)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [7:0]  bn;
    logic [31:0] dst;
    logic [31:0] src;
    logic        mem;
    logic [23:0] addr;
    logic [31:0] res;
    logic        n;
    logic        z;
    logic        af;
    logic        sf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  3'd0, 2'd2, 8'd5,  32'h0000_0020, 32'h0, 1'b0, 24'h0,      32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 bit was 1
    '{8'd5,  3'd0, 2'd2, 8'd37, 32'h0000_0000, 32'h0, 1'b0, 24'h0,      32'h0000_0020, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 37 mod 32
    '{8'd5,  3'd1, 2'd0, 8'd10, 32'hAABB_CC04, 32'h0, 1'b0, 24'h0,      32'hAABB_CC00, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R4 10 mod 8
    '{8'd4,  3'd2, 2'd0, 8'd7,  32'h1234_5600, 32'h0, 1'b0, 24'h0,      32'h1234_5680, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 set byte
    '{8'd4,  3'd2, 2'd2, 8'd31, 32'h0000_0001, 32'h0, 1'b0, 24'h0,      32'h8000_0001, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 set top bit, N kept
    '{8'd7,  3'd3, 2'd1, 8'd0,  32'hDEAD_BEEF, 32'h0, 1'b0, 24'h0,      32'hDEAD_0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 clear word
    '{8'd8,  3'd4, 2'd0, 8'd0,  32'h1111_1170, 32'h0, 1'b0, 24'h0,      32'h1111_118F, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 not byte
    '{8'd6,  3'd0, 2'd1, 8'd3,  32'h5555_5555, 32'h0, 1'b0, 24'h0,      32'h5555_5555, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 word bit op
    '{8'd8,  3'd5, 2'd2, 8'd0,  32'hF0F0_F0F0, 32'hF0F0_F0F0, 1'b0, 24'h0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 xor long
    '{8'd8,  3'd5, 2'd1, 8'd0,  32'h1234_00FF, 32'hABCD_80FF, 1'b0, 24'h0, 32'h1234_8000, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 xor word
    '{8'd9,  3'd7, 2'd0, 8'd0,  32'hFFFF_FF00, 32'h0, 1'b0, 24'h0,      32'hFFFF_FF00, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 test byte
    '{8'd11, 3'd7, 2'd1, 8'd0,  32'h0000_0000, 32'h0, 1'b1, 24'h000101, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0}, // R11 odd word
    '{8'd10, 3'd6, 2'd3, 8'd0,  32'h8765_4321, 32'h0, 1'b1, 24'h000001, 32'h4321_8765, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 swap
    '{8'd11, 3'd4, 2'd2, 8'd0,  32'h0000_0000, 32'h0, 1'b1, 24'h000100, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R11 even long
    '{8'd11, 3'd3, 2'd0, 8'd0,  32'h1234_5678, 32'h0, 1'b1, 24'h000003, 32'h1234_5600, 1'b0, 1'b1, 1'b0, 1'b0}, // R11 odd byte ok
    '{8'd6,  3'd7, 2'd3, 8'd0,  32'h0000_0001, 32'h0, 1'b0, 24'h0,      32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 size code 3
    '{8'd9,  3'd7, 2'd2, 8'd0,  32'h8000_0000, 32'h0, 1'b0, 24'h0,      32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 test long
    '{8'd11, 3'd1, 2'd2, 8'd0,  32'hFFFF_FFFF, 32'h0, 1'b1, 24'h000007, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0}  // R11 odd long
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    in_valid = 1'b0; op = 3'd0; size = 2'd0; bitnum = 8'd0;
    dst = 32'h0; src = 32'h0; mem_dst = 1'b0; addr = 24'h0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 reset", {out_valid, flag_n, flag_z, align_fault, result},
          {1'b0, 1'b0, 1'b0, 1'b0, 32'h0});
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {out_valid, flag_z, size_fault, 1'b0, result},
          {1'b0, 1'b0, 1'b0, 1'b0, 32'h0});

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op = VECS[i].op; size = VECS[i].sz; bitnum = VECS[i].bn;
      dst = VECS[i].dst; src = VECS[i].src; mem_dst = VECS[i].mem; addr = VECS[i].addr;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {out_valid, flag_n, flag_z, align_fault, result},
            {1'b1, VECS[i].n, VECS[i].z, VECS[i].af, VECS[i].res});
      check($sformatf("R%0d vector %0d size fault", VECS[i].req, i),
            {35'h0, size_fault}, {35'h0, VECS[i].sf});
    end

    // R2: idle cycle holds result and flags
    drive_idle();
    dst = 32'h1357_9BDF;
    @(negedge clk);
    check("R2 idle hold", {out_valid, flag_n, flag_z, align_fault, result},
          {1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF});

    // R1: reset mid-run clears flags and result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", {out_valid, flag_n, flag_z, align_fault, result},
          {1'b0, 1'b0, 1'b0, 1'b0, 32'h0});

    // R3: bit change of a clear bit after reset, N stays 0
    in_valid = 1'b1; op = 3'd0; size = 2'd0; bitnum = 8'd15; dst = 32'hFFFF_FF00;
    @(negedge clk);
    check("R3 change clear bit", {out_valid, flag_n, flag_z, align_fault, result},
          {1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFF_FF80});
    drive_idle();
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule